// File: doc/BRIEF.md
# Break Match Occurrence Down-Counter

This block sits beside the comparator logic of one hardware breakpoint channel. It turns a stream of match pulses into a break interrupt request, but only after a programmed number of matches has been seen. Software loads a count through a 16-bit bus register. Only the low 12 bits of that register are stored, so the largest count is 4095. Each qualifying match then lowers the count. The match that arrives while the count reads one raises the interrupt.

A level input from the break control logic switches counting on or off. With counting off, every qualifying match requests an interrupt at once and the register keeps its value. A suppression input is held high while the core runs a repeat loop of fewer than four instructions. Matches during that time are dropped entirely: they are not counted and they raise no interrupt. The interrupt output is registered, and each qualifying match produces a one-clock pulse on the cycle after it.

Top module: `brk_hit_counter`

## Requirements
- R1: After reset the register reads 0x0000 and the interrupt output is low.
- R2: A write stores only bits 11:0 of the written data. Bits 15:12 always read as zero, so writing 0xFFFF reads back 0x0FFF.
- R3: With counting disabled, a qualifying match raises the interrupt one cycle later and leaves the register unchanged.
- R4: With counting enabled and the register above one, a qualifying match lowers the register by one and raises no interrupt.
- R5: With counting enabled and the register at one, a qualifying match raises the interrupt and the register becomes zero.
- R6: With counting enabled and the register at zero, a qualifying match raises the interrupt and the register stays at zero, with no wrap.
- R7: A match presented while the short-repeat-loop input is high changes neither the register nor the interrupt, whether counting is enabled or not.
- R8: A write in the same cycle as a qualifying match loads the written value undecremented. In that cycle the interrupt decision uses the count held before the write.
- R9: The interrupt output is high for exactly the one cycle after each qualifying match and is low in every other cycle.
- R10: With no write and no qualifying match, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe for the count register |
| wr_data | input | 16 | Bus write data |
| rd_data | output | 16 | Count register read value, bits 15:12 zero |
| match_i | input | 1 | One-cycle pulse from the break comparator |
| count_en_i | input | 1 | Execution-count mode enable |
| rpt_short_i | input | 1 | High while a repeat loop of fewer than four instructions runs |
| irq_o | output | 1 | Registered one-cycle break interrupt request |

## Verification
The counting path is driven with a count of three through to zero and beyond. This separates firing on the match taken at one from firing on the match that reaches zero, and shows that a match at zero does not wrap. Matches with counting disabled, and matches with the repeat-loop input high in both modes, separate the direct path from the dropped path. A write in the same cycle as a match, tried at counts of one and seven, shows which value wins in the register and which count decides the interrupt. Back-to-back matches and idle cycles confirm that the interrupt pulse neither stretches nor misses.

// File: rtl/brkcnt_pkg.sv
package brkcnt_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2
    } cnt_act_e;
endpackage

// File: rtl/brkcnt_qual.sv
module brkcnt_qual (
    input  logic match_i,
    input  logic rpt_short_i,
    output logic accept_o
);
    // a match inside a short repeat loop is never taken
    always_comb begin
        accept_o = match_i & ~rpt_short_i;
    end
endmodule

// File: rtl/brkcnt_count.sv
module brkcnt_count #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             accept_i,
    input  logic             count_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fire_o
);
    import brkcnt_pkg::*;

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    cnt_act_e   act;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        // bus write wins over a same-cycle decrement
        if (load_i) begin
            act = ACT_LOAD;
        end else if (accept_i && count_en_i && st_q.cnt != ZERO) begin
            act = ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
        case (act)
            ACT_LOAD: st_d.cnt = load_val_i;
            ACT_DEC:  st_d.cnt = st_q.cnt - ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
        // fire decision looks at the count held before any write
        if (accept_i && (!count_en_i || st_q.cnt <= ONE)) begin
            fire_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/brkcnt_pulse.sv
module brkcnt_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d.irq = fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/brk_hit_counter.sv
module brk_hit_counter #(
    parameter int unsigned REG_W = 16,
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             match_i,
    input  logic             count_en_i,
    input  logic             rpt_short_i,
    output logic             irq_o
);
    localparam int unsigned PAD_W = REG_W - CNT_W;

    logic             accept;
    logic             fire;
    logic [CNT_W-1:0] cnt;

    brkcnt_qual u_qual (
        .match_i     (match_i),
        .rpt_short_i (rpt_short_i),
        .accept_o    (accept)
    );

    brkcnt_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_en),
        .load_val_i (wr_data[CNT_W-1:0]),
        .accept_i   (accept),
        .count_en_i (count_en_i),
        .cnt_o      (cnt),
        .fire_o     (fire)
    );

    brkcnt_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .irq_o  (irq_o)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, cnt};
        end else begin : g_nopad
            assign rd_data = cnt;
        end
    endgenerate
endmodule

// File: rtl/brkcnt_chk.sv
module brkcnt_chk #(
    parameter int unsigned REG_W = 16,
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             match_i,
    input logic             count_en_i,
    input logic             rpt_short_i,
    input logic             irq_o
);
    localparam logic [REG_W-1:0] ONE_W = REG_W'(1);

    always_comb begin
        if (rst_n) begin
            assert_upper_zero_R2: assert ((rd_data >> CNT_W) == '0);
        end
    end

    assert_direct_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !rpt_short_i && !count_en_i && !wr_en) |=> (irq_o && rd_data == $past(rd_data)));

    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !rpt_short_i && count_en_i && !wr_en && rd_data > ONE_W)
        |=> (rd_data == $past(rd_data) - ONE_W && !irq_o));

    assert_fire_at_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !rpt_short_i && count_en_i && !wr_en && rd_data == ONE_W)
        |=> (irq_o && rd_data == '0));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_i && !wr_en && rd_data == '0) |=> (rd_data == '0));

    assert_short_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && rpt_short_i && !wr_en) |=> ($stable(rd_data) && !irq_o));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[CNT_W-1:0] == $past(wr_data[CNT_W-1:0])));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(match_i && !rpt_short_i));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(match_i && !rpt_short_i)) |=> ($stable(rd_data) && !irq_o));
endmodule

bind brk_hit_counter brkcnt_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .match_i     (match_i),
    .count_en_i  (count_en_i),
    .rpt_short_i (rpt_short_i),
    .irq_o       (irq_o)
);

// File: tb/brk_hit_counter_test.sv
module brk_hit_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        match_i = 1'b0;
    logic        count_en_i = 1'b0;
    logic        rpt_short_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    brk_hit_counter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .match_i     (match_i),
        .count_en_i  (count_en_i),
        .rpt_short_i (rpt_short_i),
        .irq_o       (irq_o)
    );

    task automatic expect_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs, then sample 5 ns after the edge
    task automatic step(input logic wr, input logic [15:0] d, input logic m, input logic rpt);
        wr_en = wr;
        wr_data = d;
        match_i = m;
        rpt_short_i = rpt;
        @(posedge clk);
        #5;
        wr_en = 1'b0;
        match_i = 1'b0;
        rpt_short_i = 1'b0;
    endtask

    task automatic t_reset();
        expect_val("R1 reg", rd_data, 16'h0000);
        expect_val("R1 irq", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_width();
        step(1'b1, 16'hFFFF, 1'b0, 1'b0);
        expect_val("R2 all ones", rd_data, 16'h0FFF);
        step(1'b1, 16'hA123, 1'b0, 1'b0);
        expect_val("R2 upper dropped", rd_data, 16'h0123);
    endtask

    task automatic t_disabled();
        count_en_i = 1'b0;
        step(1'b1, 16'h0003, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        expect_val("R3 irq", {15'd0, irq_o}, 16'd1);
        expect_val("R3 reg kept", rd_data, 16'h0003);
        step(1'b0, '0, 1'b0, 1'b0);
        expect_val("R9 irq drops", {15'd0, irq_o}, 16'd0);
        expect_val("R10 hold", rd_data, 16'h0003);
    endtask

    task automatic t_countdown();
        count_en_i = 1'b1;
        step(1'b1, 16'h0003, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        expect_val("R4 reg 3->2", rd_data, 16'h0002);
        expect_val("R4 no irq", {15'd0, irq_o}, 16'd0);
        step(1'b0, '0, 1'b1, 1'b0);
        expect_val("R4 reg 2->1", rd_data, 16'h0001);
        expect_val("R4 no irq at 1", {15'd0, irq_o}, 16'd0);
        step(1'b0, '0, 1'b1, 1'b0);
        expect_val("R5 reg to 0", rd_data, 16'h0000);
        expect_val("R5 irq", {15'd0, irq_o}, 16'd1);
        step(1'b0, '0, 1'b0, 1'b0);
        expect_val("R9 single pulse", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_zero();
        count_en_i = 1'b1;
        step(1'b0, '0, 1'b1, 1'b0);
        expect_val("R6 irq at zero", {15'd0, irq_o}, 16'd1);
        expect_val("R6 no wrap", rd_data, 16'h0000);
    endtask

    task automatic t_repeat();
        count_en_i = 1'b1;
        step(1'b1, 16'h0002, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b1);
        expect_val("R7 reg kept en", rd_data, 16'h0002);
        expect_val("R7 no irq en", {15'd0, irq_o}, 16'd0);
        step(1'b1, 16'h0001, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b1);
        expect_val("R7 no irq at one", {15'd0, irq_o}, 16'd0);
        expect_val("R7 reg kept at one", rd_data, 16'h0001);
        count_en_i = 1'b0;
        step(1'b0, '0, 1'b1, 1'b1);
        expect_val("R7 no irq dis", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_collide();
        count_en_i = 1'b1;
        step(1'b1, 16'h0001, 1'b0, 1'b0);
        step(1'b1, 16'h0007, 1'b1, 1'b0);
        expect_val("R8 write wins", rd_data, 16'h0007);
        expect_val("R8 irq from old count", {15'd0, irq_o}, 16'd1);
        step(1'b1, 16'h0009, 1'b1, 1'b0);
        expect_val("R8 write wins 2", rd_data, 16'h0009);
        expect_val("R8 no irq old 7", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_back2back();
        count_en_i = 1'b0;
        step(1'b0, '0, 1'b1, 1'b0);
        expect_val("R9 first", {15'd0, irq_o}, 16'd1);
        step(1'b0, '0, 1'b1, 1'b0);
        expect_val("R9 second", {15'd0, irq_o}, 16'd1);
        step(1'b0, '0, 1'b0, 1'b0);
        expect_val("R9 ends", {15'd0, irq_o}, 16'd0);
        expect_val("R10 hold after", rd_data, 16'h0009);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        t_width();
        t_disabled();
        t_countdown();
        t_zero();
        t_repeat();
        t_collide();
        t_back2back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule